// File: doc/BRIEF.md
# Carry-Increment Grouped Adder

A purely combinational adder that takes two WIDTH-bit operands and a carry-in and returns their WIDTH-bit sum and a carry-out. The operand bits are cut into groups whose sizes come from a parameter array, and neighbouring groups may have different sizes. Bitwise generate and propagate terms are formed once for the whole word. Each group then builds prefix generate/propagate terms over its own bits. From these it produces a sum that assumes no carry enters the group, plus the group's overall generate and propagate.

A short chain across the groups turns the group generate/propagate pairs into the carry that enters each group. Each group's zero-carry sum is then corrected by an increment mask: the prefix propagate terms ANDed with the true group carry. A single word-wide XOR at the top applies the correction for every group at once. Nothing is duplicated per carry value and there is no per-group multiplexer.

The carry entering every group is brought out, so that the group chain can be observed. If the group sizes do not add up to WIDTH, elaboration stops.

Top module: `cia_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, taken as unsigned numbers; with all inputs at zero, `sum`, `cout` and `grp_carry` are all zero.
- R2: `cout` equals bit WIDTH of the unsigned sum `a + b + cin`.
- R3: `grp_carry[0]` (the carry into the lowest group, whose least significant bit is operand bit 0) always equals `cin`.
- R4: For group g ≥ 1, starting at bit s (s being the sum of the sizes of groups 0..g-1), `grp_carry[g]` equals the carry that a plain ripple addition of `a`, `b` and `cin` delivers into bit s.
- R5: When `a ^ b` is all ones, the carry passes through every group: `cout` equals `cin` and `sum` is all ones when `cin` is 0 and all zeros when `cin` is 1.
- R6: With WIDTH = 8 and the non-uniform group sizes 1, 3, 4 (lowest group first), every combination of operands and carry-in satisfies R1 to R4.
- R7: A carry generated only in the top bit of a group (both operands have a single one there and are zero elsewhere, cin = 0) sets the carry into the next group, and the sum is a single one in that group's lowest bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |
| grp_carry | output | NGRP | Carry entering each group, index 0 = lowest group |

## Verification
The bench targets four cases:

- **Full-length propagate.** Operands whose XOR is all ones make the carry cross every group. An adder that dropped the group propagate term from the chain would return a carry-out of zero here.
- **Carry born at a group's top bit.** A carry generated at the most significant bit of a group must appear only at the next group's input. An off-by-one in a group's start offset would put the one in the wrong sum bit.
- **Non-uniform 8-bit configuration.** This configuration is run exhaustively, including the one-bit group. A broken empty-prefix identity would spoil the increment mask there.
- **Random 32-bit operands.** These catch errors in the carry chain or in the increment mask that depend on the data.

// File: rtl/cia_pkg.sv
package cia_pkg;

  // generate/propagate pair of a bit span
  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // span identity: no generate, full propagate
  localparam pg_t PG_EMPTY = '{g: 1'b0, p: 1'b1};

  // join an upper span onto a lower adjacent span
  function automatic pg_t pg_merge(pg_t upper, pg_t lower);
    pg_t r;
    r.g = upper.g | (upper.p & lower.g);
    r.p = upper.p & lower.p;
    return r;
  endfunction

  // carry leaving a span for a given carry entering it
  function automatic logic span_carry(pg_t span, logic c);
    return span.g | (span.p & c);
  endfunction

endpackage

// File: rtl/cia_bitpg.sv
module cia_bitpg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  // shared bitwise stage, computed once for the whole word
  assign gen  = a & b;
  assign prop = a ^ b;
endmodule

// File: rtl/cia_group.sv
module cia_group #(
  parameter int unsigned SIZE = 4
) (
  input  logic [SIZE-1:0] gen,
  input  logic [SIZE-1:0] prop,
  input  logic            grp_cin,
  output logic [SIZE-1:0] sum0,
  output logic [SIZE-1:0] inc_mask,
  output logic            grp_g,
  output logic            grp_p
);
  import cia_pkg::*;

  // prefix spans: pre[i] covers group bits i-1 down to 0
  pg_t pre [SIZE+1];

  always_comb begin
    pre[0] = PG_EMPTY;
    for (int i = 0; i < SIZE; i++) begin
      pre[i+1] = pg_merge('{g: gen[i], p: prop[i]}, pre[i]);
    end
  end

  // zero-carry result and late-carry increment mask per bit
  always_comb begin
    for (int i = 0; i < SIZE; i++) begin
      sum0[i]     = prop[i] ^ pre[i].g;
      inc_mask[i] = pre[i].p & grp_cin;
    end
  end

  assign grp_g = pre[SIZE].g;
  assign grp_p = pre[SIZE].p;
endmodule

// File: rtl/cia_chain.sv
module cia_chain #(
  parameter int unsigned NGRP = 6
) (
  input  logic [NGRP-1:0] grp_g,
  input  logic [NGRP-1:0] grp_p,
  input  logic            cin,
  output logic [NGRP-1:0] grp_cin,
  output logic            cout
);
  import cia_pkg::*;

  logic [NGRP:0] link;

  assign link[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_link
    assign link[g+1] = span_carry('{g: grp_g[g], p: grp_p[g]}, link[g]);
  end

  assign grp_cin = link[NGRP-1:0];
  assign cout    = link[NGRP];
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NGRP  = 6,
  parameter int unsigned GSIZE [NGRP] = '{2, 3, 4, 6, 8, 9}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic [NGRP-1:0]  grp_carry
);

  function automatic int unsigned grp_start(int unsigned idx);
    int unsigned s = 0;
    for (int unsigned k = 0; k < idx; k++) s += GSIZE[k];
    return s;
  endfunction

  localparam int unsigned TOTAL = grp_start(NGRP);

  if (TOTAL != WIDTH) begin : g_bad_sizes
    $error("cia_adder: group sizes total %0d, WIDTH is %0d", TOTAL, WIDTH);
  end

  logic [WIDTH-1:0] gen, prop;
  logic [WIDTH-1:0] sum0_all, inc_all;
  logic [NGRP-1:0]  gg, gp, gcin;

  cia_bitpg #(.WIDTH(WIDTH)) u_bitpg (
    .a   (a),
    .b   (b),
    .gen (gen),
    .prop(prop)
  );

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int unsigned S  = grp_start(gi);
    localparam int unsigned SZ = GSIZE[gi];
    cia_group #(.SIZE(SZ)) u_grp (
      .gen     (gen[S +: SZ]),
      .prop    (prop[S +: SZ]),
      .grp_cin (gcin[gi]),
      .sum0    (sum0_all[S +: SZ]),
      .inc_mask(inc_all[S +: SZ]),
      .grp_g   (gg[gi]),
      .grp_p   (gp[gi])
    );
  end

  cia_chain #(.NGRP(NGRP)) u_chain (
    .grp_g  (gg),
    .grp_p  (gp),
    .cin    (cin),
    .grp_cin(gcin),
    .cout   (cout)
  );

  // one shared correction XOR for every group
  assign sum       = sum0_all ^ inc_all;
  assign grp_carry = gcin;

endmodule

// File: rtl/cia_adder_chk.sv
module cia_adder_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NGRP  = 6,
  parameter int unsigned GSIZE [NGRP] = '{2, 3, 4, 6, 8, 9}
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP-1:0]  grp_carry
);

  function automatic int unsigned start_of(int unsigned idx);
    int unsigned s = 0;
    for (int unsigned k = 0; k < idx; k++) s += GSIZE[k];
    return s;
  endfunction

  logic [WIDTH:0] whole;
  assign whole = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    a_r1_sum_value: assert (sum == whole[WIDTH-1:0])
      else $error("R1 sum %h expected %h", sum, whole[WIDTH-1:0]);
    a_r2_carry_out: assert (cout == whole[WIDTH])
      else $error("R2 cout %b", cout);
    a_r3_first_group: assert (grp_carry[0] == cin)
      else $error("R3 grp_carry[0] differs from cin");
    if ((a ^ b) == '1) begin
      a_r5_full_propagate: assert (cout == cin && sum == {WIDTH{~cin}})
        else $error("R5 propagate case broken");
    end
  end

  always_comb begin
    for (int unsigned g = 1; g < NGRP; g++) begin
      logic [WIDTH:0] mask, part;
      mask = ({{WIDTH{1'b0}}, 1'b1} << start_of(g)) - 1'b1;
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, cin};
      a_r4_group_chain: assert (grp_carry[g] == part[start_of(g)])
        else $error("R4 group %0d carry wrong", g);
    end
  end

endmodule

bind cia_adder cia_adder_chk #(
  .WIDTH(WIDTH), .NGRP(NGRP), .GSIZE(GSIZE)
) u_chk (.*);

// File: tb/cia_adder_test.sv
`timescale 1ns/1ps
module cia_adder_test;

  localparam int unsigned W32 = 32;
  localparam int unsigned N32 = 6;
  localparam int unsigned S32 [N32] = '{2, 3, 4, 6, 8, 9};
  localparam int unsigned W8  = 8;
  localparam int unsigned N8  = 3;
  localparam int unsigned S8  [N8] = '{1, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;

  logic [W32-1:0] a32, b32, s32;
  logic           c32, co32;
  logic [N32-1:0] gc32;
  logic [W8-1:0]  a8, b8, s8;
  logic           c8, co8;
  logic [N8-1:0]  gc8;

  cia_adder uut (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32), .grp_carry(gc32)
  );

  cia_adder #(.WIDTH(W8), .NGRP(N8), .GSIZE(S8)) uut_n8 (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8), .grp_carry(gc8)
  );

  // bench model: bit-serial ripple, carries[i] is the carry into bit i
  function automatic logic [W32:0] ripple(logic [W32-1:0] x, logic [W32-1:0] y,
                                          logic c, int w);
    logic [W32:0] cy = '0;
    cy[0] = c;
    for (int i = 0; i < w; i++)
      cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] | y[i]));
    return cy;
  endfunction

  function automatic logic [W32-1:0] ref_sum(logic [W32-1:0] x, logic [W32-1:0] y,
                                             logic c, int w);
    logic [W32:0] cy = ripple(x, y, c, w);
    return x ^ y ^ cy[W32-1:0];
  endfunction

  task automatic report(string req, logic ok, logic [W32:0] act, logic [W32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run32(logic [W32-1:0] x, logic [W32-1:0] y, logic c, string tag);
    logic [W32:0] cy;
    logic [W32-1:0] es;
    int st;
    @(posedge clk);
    a32 = x; b32 = y; c32 = c;
    @(negedge clk);
    cy = ripple(x, y, c, W32);
    es = ref_sum(x, y, c, W32);
    report({tag, " R1 sum"}, s32 == es, {1'b0, s32}, {1'b0, es});
    report({tag, " R2 cout"}, co32 == cy[W32], {32'd0, co32}, {32'd0, cy[W32]});
    report({tag, " R3 grp0"}, gc32[0] == c, {32'd0, gc32[0]}, {32'd0, c});
    st = 0;
    for (int g = 0; g < N32; g++) begin
      report({tag, " R4 grp carry"}, gc32[g] == cy[st], {32'd0, gc32[g]}, {32'd0, cy[st]});
      st += S32[g];
    end
  endtask

  task automatic run8(logic [W8-1:0] x, logic [W8-1:0] y, logic c);
    logic [W32:0] cy;
    logic [W32-1:0] es;
    logic ok;
    int st;
    @(posedge clk);
    a8 = x; b8 = y; c8 = c;
    @(negedge clk);
    cy = ripple({24'd0, x}, {24'd0, y}, c, W8);
    es = ref_sum({24'd0, x}, {24'd0, y}, c, W8);
    ok = (s8 == es[W8-1:0]) && (co8 == cy[W8]) && (gc8[0] == c);
    st = 0;
    for (int g = 0; g < N8; g++) begin
      ok = ok && (gc8[g] == cy[st]);
      st += S8[g];
    end
    // R6: exhaustive 8-bit non-uniform sizes
    report("R6 8-bit", ok, {24'd0, co8, gc8, s8}, {22'd0, cy[W8], gc8, es[W8-1:0]});
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    int st;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    seed = 32'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: zero inputs give all-zero outputs
    report("R1 reset zero", s32 == '0 && co32 == 1'b0 && gc32 == '0,
           {co32, s32}, '0);
    rst_n = 1'b1;

    // R5: full-length propagate, both carry-in values
    run32(32'hFFFF_0000, 32'h0000_FFFF, 1'b1, "R5");
    report("R5 cout", co32 == 1'b1 && s32 == '0, {co32, s32}, {1'b1, 32'd0});
    run32(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0, "R5");
    report("R5 cout0", co32 == 1'b0 && s32 == '1, {co32, s32}, {1'b0, 32'hFFFF_FFFF});

    // R7: carry born in the top bit of each group but the last
    st = 0;
    for (int g = 0; g < N32 - 1; g++) begin
      logic [W32-1:0] bit_top;
      st += S32[g];
      bit_top = 32'd1 << (st - 1);
      run32(bit_top, bit_top, 1'b0, "R7");
      report("R7 next group carry", gc32[g+1] == 1'b1 && s32 == (32'd1 << st),
             {gc32[g+1], s32}, {1'b1, 32'd1 << st});
    end

    // directed extremes
    run32('1, '1, 1'b1, "R2 max");
    run32('1, 32'd0, 1'b1, "R2 wrap");
    run32(32'd0, 32'd0, 1'b1, "R3 cin only");

    // R1/R2/R4: random 32-bit operands, fixed seed
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++)
      run32($urandom, $urandom, 1'($urandom), "rand");

    // R6: every 8-bit combination
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          run8(8'(x), 8'(y), 1'(c));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule